// File: doc/BRIEF.md
# Down-Counting Timer Bank

The block is a bank of independent down-counting timer channels behind a small single-cycle register bus. Each channel counts down by one on every pulse of a shared tick-enable input. A channel only counts while the bank-wide enable and its own enable are both set. When a channel reaches zero it reloads from its reload register, adds one to a free-running overflow counter and raises a sticky status flag. The channel's interrupt line is that flag gated by a per-channel mask.

Software reads a channel's time in two steps. A read of the overflow register returns the number of wraps. In the same cycle it copies the live count into the current-value register. A later read of the current-value register returns that copy, so the two words always belong to the same instant. The counting clock is supplied from outside as the tick-enable pulse. Clock-source selection is not part of this block.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every readable register is zero except each reload register (0xFFFFFFFF) and the revision register; all interrupt outputs are low and the read-data output is zero.
- R2: Byte address 0x00 holds the bank enable in bit 0 (read/write, other bits read zero). Address 0x10 is a read-only revision word of value 0x00010200, and writes to it are ignored.
- R3: A channel's count changes on a cycle with tick asserted only while the bank enable and the channel's enable are both 1. Without a tick or a register write, no count changes.
- R4: Channel n's window starts at byte 0x20·(n+1). Within it, the offsets are: 0x00 configuration (bit 0 = channel enable), 0x04 reload, 0x08 captured count, 0x0C overflow count, 0x10 status (bit 0), 0x14 clear, 0x18 mask (bit 0). Each channel is controlled only through its own window.
- R5: A write that sets the configuration enable bit while it is 0 loads the reload value into the count at that same clock edge.
- R6: A counting tick with a count of 0 reloads the count from the reload register, increments the 32-bit overflow count and sets the status bit. Any other counting tick decrements the count by one, so a channel wraps once every reload+1 counting ticks.
- R7: A read of the overflow register copies the count as it stood before that edge into the captured-count register. The captured-count register keeps that value until the next overflow read, whatever the live count does.
- R8: Interrupt output n equals status AND mask bit 0 of channel n. A mask of 0 keeps the output low while status is set.
- R9: Writing 1 in bit 0 of the clear register clears status. If a wrap occurs in the same cycle, status stays set.
- R10: Read data is registered. The value appears the cycle after a read and holds until the next read. The clear register reads as zero.
- R11: Unaligned addresses, unused offsets inside a window, and addresses at or above 0x20·(channels+1) read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable pulse, one count per asserted cycle |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | NUM_CH (4) | Per-channel interrupt, status AND mask |

## Verification
The hardest situation to reach is a clear arriving in exactly the cycle a channel wraps, because the wrap instant depends on the reload value, the enable history and every earlier tick. The bench tracks the live count in its reference model. It ticks until the model reports a count of zero, then issues the clear together with a tick, so the collision happens deterministically. A long random phase with short reload values and frequent overflow and captured-count reads also produces snapshot reads taken on wrap edges and on enable-rising edges.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

   // Register slot selected inside a channel window
   typedef enum logic [2:0] {
      SLOT_CFG    = 3'd0,
      SLOT_RELOAD = 3'd1,
      SLOT_SNAP   = 3'd2,
      SLOT_WRAPS  = 3'd3,
      SLOT_STAT   = 3'd4,
      SLOT_CLR    = 3'd5,
      SLOT_MASK   = 3'd6,
      SLOT_NONE   = 3'd7
   } tmr_slot_e;

   localparam int unsigned WIN_LSB = 5;            // 32-byte windows
   localparam logic [4:0]  OFF_CTRL = 5'h00;
   localparam logic [4:0]  OFF_REV  = 5'h10;

   function automatic tmr_slot_e slot_of(input logic [4:0] off);
      case (off)
         5'h00:   slot_of = SLOT_CFG;
         5'h04:   slot_of = SLOT_RELOAD;
         5'h08:   slot_of = SLOT_SNAP;
         5'h0C:   slot_of = SLOT_WRAPS;
         5'h10:   slot_of = SLOT_STAT;
         5'h14:   slot_of = SLOT_CLR;
         5'h18:   slot_of = SLOT_MASK;
         default: slot_of = SLOT_NONE;
      endcase
   endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_ctrl_o,
   output logic              hit_rev_o,
   output logic [NUM_CH-1:0] ch_sel_o,
   output tmr_slot_e         slot_o
);

   localparam int unsigned WIN_W = ADDR_W - WIN_LSB;

   logic [WIN_W-1:0] win;
   logic [4:0]       off;
   tmr_slot_e        slot;

   assign win  = addr_i[ADDR_W-1:WIN_LSB];
   assign off  = addr_i[WIN_LSB-1:0];
   assign slot = slot_of(off);

   always_comb begin
      hit_ctrl_o = 1'b0;
      hit_rev_o  = 1'b0;
      ch_sel_o   = '0;
      slot_o     = SLOT_NONE;
      if (valid_i) begin
         if (win == '0) begin
            hit_ctrl_o = (off == OFF_CTRL);
            hit_rev_o  = (off == OFF_REV);
         end else if (slot != SLOT_NONE) begin
            slot_o = slot;
            for (int i = 0; i < int'(NUM_CH); i++) begin
               if (win == WIN_W'(i + 1)) ch_sel_o[i] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_bank_pkg::*;
#(
   parameter int unsigned     CNT_W      = 32,
   parameter int unsigned     DATA_W     = 32,
   parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bank_en_i,
   input  logic              sel_i,
   input  logic              write_i,
   input  tmr_slot_e         slot_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rd_val_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              status_o,
   output logic              irq_o
);

   logic              en_q, mask_q, stat_q;
   logic [CNT_W-1:0]  reload_q, cnt_q, snap_q;
   logic [DATA_W-1:0] wraps_q;

   logic wr_cfg, wr_reload, wr_mask, wr_clr, rd_wraps;
   logic counting, at_zero, wrap, en_rise;

   assign wr_cfg    = sel_i &&  write_i && (slot_i == SLOT_CFG);
   assign wr_reload = sel_i &&  write_i && (slot_i == SLOT_RELOAD);
   assign wr_mask   = sel_i &&  write_i && (slot_i == SLOT_MASK);
   assign wr_clr    = sel_i &&  write_i && (slot_i == SLOT_CLR);
   assign rd_wraps  = sel_i && !write_i && (slot_i == SLOT_WRAPS);

   assign counting = bank_en_i && en_q && tick_i;
   assign at_zero  = (cnt_q == '0);
   assign wrap     = counting && at_zero;
   assign en_rise  = wr_cfg && wdata_i[0] && !en_q;

   // configuration, reload and mask
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q     <= 1'b0;
         mask_q   <= 1'b0;
         reload_q <= RELOAD_RST;
      end else begin
         if (wr_cfg)    en_q     <= wdata_i[0];
         if (wr_mask)   mask_q   <= wdata_i[0];
         if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
      end
   end

   // live counter, wrap count and snapshot
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         wraps_q <= '0;
         snap_q  <= '0;
      end else begin
         if (en_rise)       cnt_q <= reload_q;
         else if (counting) cnt_q <= at_zero ? reload_q : cnt_q - 1'b1;
         if (wrap)          wraps_q <= wraps_q + 1'b1;
         if (rd_wraps)      snap_q  <= cnt_q;
      end
   end

   // sticky status, a wrap beats a simultaneous clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     stat_q <= 1'b0;
      else if (wrap)                   stat_q <= 1'b1;
      else if (wr_clr && wdata_i[0])   stat_q <= 1'b0;
   end

   always_comb begin
      rd_val_o = '0;
      case (slot_i)
         SLOT_CFG:    rd_val_o[0] = en_q;
         SLOT_RELOAD: rd_val_o    = DATA_W'(reload_q);
         SLOT_SNAP:   rd_val_o    = DATA_W'(snap_q);
         SLOT_WRAPS:  rd_val_o    = wraps_q;
         SLOT_STAT:   rd_val_o[0] = stat_q;
         SLOT_MASK:   rd_val_o[0] = mask_q;
         default:     rd_val_o    = '0;
      endcase
   end

   assign count_o  = cnt_q;
   assign status_o = stat_q;
   assign irq_o    = stat_q & mask_q;

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
   parameter int unsigned        NUM_CH = 4,
   parameter int unsigned        DATA_W = 32,
   parameter logic [DATA_W-1:0]  REV_ID = '0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     rd_i,
   input  logic                     hit_ctrl_i,
   input  logic                     hit_rev_i,
   input  logic                     bank_en_i,
   input  logic [NUM_CH-1:0]        ch_sel_i,
   input  logic [NUM_CH*DATA_W-1:0] ch_val_i,
   output logic [DATA_W-1:0]        rdata_o
);

   logic [DATA_W-1:0] mux_val;

   always_comb begin
      mux_val = '0;
      if (hit_ctrl_i) mux_val[0] = bank_en_i;
      if (hit_rev_i)  mux_val    = REV_ID;
      for (int i = 0; i < int'(NUM_CH); i++) begin
         if (ch_sel_i[i]) mux_val = mux_val | ch_val_i[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_o <= '0;
      else if (rd_i) rdata_o <= mux_val;
   end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import tmr_bank_pkg::*;
#(
   parameter int unsigned        NUM_CH = 4,
   parameter int unsigned        CNT_W  = 32,
   parameter int unsigned        ADDR_W = 8,
   parameter int unsigned        DATA_W = 32,
   parameter logic [DATA_W-1:0]  REV_ID = 32'h0001_0200
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              bus_valid_i,
   input  logic              bus_write_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int unsigned SPAN = (NUM_CH + 1) << WIN_LSB;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("tick_timer_bank: NUM_CH must be at least 1");
   end
   if (ADDR_W <= WIN_LSB || SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("tick_timer_bank: ADDR_W too narrow for NUM_CH windows");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("tick_timer_bank: CNT_W must lie in 2..DATA_W");
   end

   logic                     bank_en_q;
   logic                     hit_ctrl, hit_rev;
   logic [NUM_CH-1:0]        ch_sel;
   tmr_slot_e                slot;
   logic [NUM_CH*DATA_W-1:0] ch_val;
   logic [NUM_CH*CNT_W-1:0]  ch_count;
   logic [NUM_CH-1:0]        ch_status;

   tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
      .valid_i    (bus_valid_i),
      .addr_i     (bus_addr_i),
      .hit_ctrl_o (hit_ctrl),
      .hit_rev_o  (hit_rev),
      .ch_sel_o   (ch_sel),
      .slot_o     (slot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     bank_en_q <= 1'b0;
      else if (hit_ctrl && bus_write_i) bank_en_q <= bus_wdata_i[0];
   end

   for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .tick_i    (tick_i),
         .bank_en_i (bank_en_q),
         .sel_i     (ch_sel[g]),
         .write_i   (bus_write_i),
         .slot_i    (slot),
         .wdata_i   (bus_wdata_i),
         .rd_val_o  (ch_val[g*DATA_W +: DATA_W]),
         .count_o   (ch_count[g*CNT_W +: CNT_W]),
         .status_o  (ch_status[g]),
         .irq_o     (irq_o[g])
      );
   end

   tmr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REV_ID(REV_ID)) u_rdmux (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_i       (bus_valid_i && !bus_write_i),
      .hit_ctrl_i (hit_ctrl),
      .hit_rev_i  (hit_rev),
      .bank_en_i  (bank_en_q),
      .ch_sel_i   (ch_sel),
      .ch_val_i   (ch_val),
      .rdata_o    (bus_rdata_o)
   );

endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    tick_i,
   input logic                    bus_valid_i,
   input logic                    bus_write_i,
   input logic [ADDR_W-1:0]       bus_addr_i,
   input logic [DATA_W-1:0]       bus_wdata_i,
   input logic [DATA_W-1:0]       bus_rdata_o,
   input logic [NUM_CH-1:0]       irq_o,
   input logic                    bank_en_q,
   input logic [NUM_CH*CNT_W-1:0] ch_count,
   input logic [NUM_CH-1:0]       ch_status
);

   localparam int unsigned LIMIT = (NUM_CH + 1) * 32;

   AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (irq_o == '0 && bus_rdata_o == '0)); // R1

   AST_BANK_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && bus_write_i && bus_addr_i == '0) |=> (bank_en_q == $past(bus_wdata_i[0]))); // R2

   AST_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !(bus_valid_i && bus_write_i)) |=> $stable(ch_count)); // R3

   AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && !bus_write_i && int'(bus_addr_i) >= int'(LIMIT)) |=> (bus_rdata_o == '0)); // R11

   AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_valid_i && !bus_write_i) |=> $stable(bus_rdata_o)); // R10

   for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch_prop
      AST_STATUS_FROM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(ch_status[g]) |-> ($past(tick_i) && $past(ch_count[g*CNT_W +: CNT_W] == '0))); // R6
      AST_STATUS_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(ch_status[g]) |-> $past(bus_valid_i && bus_write_i && bus_wdata_i[0])); // R9
      AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(irq_o[g]) |-> (ch_status[g] || $past(ch_status[g]) || $rose(ch_status[g]))); // R8
   end

endmodule

bind tick_timer_bank tick_timer_bank_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_i      (tick_i),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .bank_en_q   (bank_en_q),
   .ch_count    (ch_count),
   .ch_status   (ch_status)
);

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb_top;

   localparam int NCH = 4;
   localparam logic [31:0] REV = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        valid = 1'b0;
   logic        write = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   always #5 clk = ~clk;

   tick_timer_bank dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   // behavioural reference state
   int unsigned m_cnt[NCH], m_rel[NCH], m_snap[NCH], m_wraps[NCH];
   bit          m_en[NCH], m_st[NCH], m_mask[NCH];
   bit          m_glob;
   logic [31:0] m_rdata;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   function automatic void model_reset();
      for (int i = 0; i < NCH; i++) begin
         m_cnt[i] = 0; m_rel[i] = 32'hFFFF_FFFF; m_snap[i] = 0; m_wraps[i] = 0;
         m_en[i] = 0; m_st[i] = 0; m_mask[i] = 0;
      end
      m_glob = 0; m_rdata = '0;
   endfunction

   // returns channel index or -1; loc is the offset inside the window
   function automatic int chan_of(logic [7:0] a);
      int w = int'(a[7:5]);
      if (w >= 1 && w <= NCH) return w - 1;
      return -1;
   endfunction

   function automatic logic [31:0] model_read(logic [7:0] a);
      int c = chan_of(a);
      logic [4:0] loc = a[4:0];
      if (a == 8'h00) return {31'b0, m_glob};
      if (a == 8'h10) return REV;
      if (c < 0) return '0;
      case (loc)
         5'h00: return {31'b0, m_en[c]};
         5'h04: return m_rel[c];
         5'h08: return m_snap[c];
         5'h0C: return m_wraps[c];
         5'h10: return {31'b0, m_st[c]};
         5'h18: return {31'b0, m_mask[c]};
         default: return '0;
      endcase
   endfunction

   function automatic void model_step(bit v, bit w, logic [7:0] a, logic [31:0] d, bit t);
      int c = v ? chan_of(a) : -1;
      logic [4:0] loc = a[4:0];
      if (v && !w) m_rdata = model_read(a);
      for (int i = 0; i < NCH; i++) begin
         bit me   = (c == i);
         bit act  = m_glob && m_en[i] && t;
         bit wrp  = act && (m_cnt[i] == 0);
         int unsigned old = m_cnt[i];
         if (me && w && loc == 5'h00 && d[0] && !m_en[i]) m_cnt[i] = m_rel[i];
         else if (act) m_cnt[i] = wrp ? m_rel[i] : old - 1;
         if (me && !w && loc == 5'h0C) m_snap[i] = old;
         if (wrp) m_wraps[i] = m_wraps[i] + 1;
         if (wrp) m_st[i] = 1;
         else if (me && w && loc == 5'h14 && d[0]) m_st[i] = 0;
         if (me && w && loc == 5'h00) m_en[i] = d[0];
         if (me && w && loc == 5'h04) m_rel[i] = d;
         if (me && w && loc == 5'h18) m_mask[i] = d[0];
      end
      if (v && w && a == 8'h00) m_glob = d[0];
   endfunction

   function automatic void compare();
      logic [3:0] exp_irq;
      for (int i = 0; i < NCH; i++) exp_irq[i] = m_st[i] & m_mask[i];
      n_cmp++;
      if (rdata !== m_rdata || irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s rdata=%h expected %h irq=%b expected %b at %0t",
                  cur_req, rdata, m_rdata, irq, exp_irq, $time);
      end
   endfunction

   task automatic cyc(bit v, bit w, logic [7:0] a, logic [31:0] d, bit t);
      @(negedge clk);
      compare();
      valid = v; write = w; addr = a; wdata = d; tick = t;
      model_step(v, w, a, d, t);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, bit t = 0); cyc(1, 1, a, d, t); endtask
   task automatic rd(logic [7:0] a, bit t = 0);                 cyc(1, 0, a, '0, t); endtask
   task automatic idle(int n, bit t);
      for (int k = 0; k < n; k++) cyc(0, 0, 8'h00, '0, t);
   endtask

   function automatic logic [7:0] ca(int ch, logic [4:0] off);
      return 8'((ch + 1) * 32) | {3'b0, off};
   endfunction

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values across the map
      cur_req = "R1";
      rd(8'h00); rd(8'h10);
      for (int i = 0; i < NCH; i++) begin
         rd(ca(i, 5'h00)); rd(ca(i, 5'h04)); rd(ca(i, 5'h08));
         rd(ca(i, 5'h0C)); rd(ca(i, 5'h10)); rd(ca(i, 5'h18));
      end

      // R2: bank enable readback, revision is read-only
      cur_req = "R2";
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
      wr(8'h00, 32'h0); rd(8'h00);
      wr(8'h10, 32'hDEAD_BEEF); rd(8'h10);

      // R5: enable rising loads reload; R3: bank disabled blocks counting
      cur_req = "R5";
      wr(ca(0, 5'h04), 32'd5); wr(ca(0, 5'h00), 32'd1);
      rd(ca(0, 5'h0C)); rd(ca(0, 5'h08));
      cur_req = "R3";
      idle(4, 1);
      rd(ca(0, 5'h0C)); rd(ca(0, 5'h08));
      wr(8'h00, 32'd1);
      idle(3, 1); idle(3, 0);
      rd(ca(0, 5'h0C)); rd(ca(0, 5'h08));

      // R6: wraps at zero, reload, wrap count
      cur_req = "R6";
      idle(9, 1);
      rd(ca(0, 5'h0C)); rd(ca(0, 5'h08)); rd(ca(0, 5'h10));

      // R7: snapshot holds while the live count moves
      cur_req = "R7";
      rd(ca(0, 5'h0C), 1);
      idle(3, 1);
      rd(ca(0, 5'h08), 1); rd(ca(0, 5'h08)); rd(ca(0, 5'h0C)); rd(ca(0, 5'h08));

      // R8: mask gates the interrupt
      cur_req = "R8";
      idle(2, 0);
      wr(ca(0, 5'h18), 32'd1); idle(2, 0);
      wr(ca(0, 5'h18), 32'd0); idle(2, 0);
      wr(ca(0, 5'h18), 32'd1);

      // R9: clear, then clear colliding with a wrap
      cur_req = "R9";
      wr(ca(0, 5'h14), 32'd1); rd(ca(0, 5'h10));
      while (m_cnt[0] != 0) idle(1, 1);
      wr(ca(0, 5'h14), 32'd1, 1); rd(ca(0, 5'h10));
      wr(ca(0, 5'h14), 32'd0); rd(ca(0, 5'h10));
      wr(ca(0, 5'h14), 32'd1); rd(ca(0, 5'h10));

      // R10: read data holds across idle cycles and writes
      cur_req = "R10";
      rd(8'h10); idle(3, 1); wr(ca(1, 5'h04), 32'd7); rd(ca(0, 5'h14));

      // R4: channel windows are independent
      cur_req = "R4";
      wr(ca(2, 5'h04), 32'd2); wr(ca(2, 5'h00), 32'd1);
      wr(ca(3, 5'h18), 32'd1);
      idle(7, 1);
      for (int i = 0; i < NCH; i++) begin
         rd(ca(i, 5'h0C)); rd(ca(i, 5'h08)); rd(ca(i, 5'h10)); rd(ca(i, 5'h04));
      end

      // R11: unmapped and unaligned accesses
      cur_req = "R11";
      wr(8'h04, 32'd1); wr(ca(0, 5'h1C), 32'd9); wr(ca(1, 5'h05), 32'd3);
      wr(8'hA4, 32'd1); wr(8'hFF, 32'hFFFF_FFFF);
      rd(8'h04); rd(ca(0, 5'h1C)); rd(ca(1, 5'h05)); rd(8'hA0); rd(8'hFC);
      rd(ca(1, 5'h04)); rd(ca(1, 5'h00)); rd(8'h00);

      // random mix, short reloads so wraps are frequent
      cur_req = "R6";
      for (int k = 0; k < 4000; k++) begin
         int ch = int'($urandom_range(0, NCH - 1));
         int op = int'($urandom_range(0, 15));
         bit t  = 1'($urandom_range(0, 1));
         case (op)
            0:  wr(ca(ch, 5'h00), {31'b0, 1'($urandom_range(0, 1))}, t);
            1:  wr(ca(ch, 5'h04), 32'($urandom_range(0, 12)), t);
            2:  wr(ca(ch, 5'h18), {31'b0, 1'($urandom_range(0, 1))}, t);
            3:  wr(ca(ch, 5'h14), {31'b0, 1'($urandom_range(0, 1))}, t);
            4, 5: rd(ca(ch, 5'h0C), t);
            6, 7: rd(ca(ch, 5'h08), t);
            8:  rd(ca(ch, 5'h10), t);
            9:  rd(ca(ch, 5'h00), t);
            10: rd(8'($urandom_range(0, 255)), t);
            11: if ($urandom_range(0, 9) == 0) wr(8'h00, {31'b0, 1'($urandom_range(0, 3) != 0)}, t);
                else idle(1, t);
            default: idle(1, t);
         endcase
      end
      idle(2, 0);

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule